// File: doc/BRIEF.md
# Codec Serial Port Framing Controller

This block is the digital side of a voice-band codec's link to a DSP serial port. It divides the master clock by four to make the bit clock. It frames every transfer with two active-low syncs, one for each direction. It shifts a 16-bit word out to the DSP and, at the same time, shifts a 16-bit word in from the DSP, most significant bit first.

A pulse on the frame tick input asks for a primary frame, and a pulse on the secondary request input asks for a secondary frame. Requests are latched and begin at the next bit-clock rising edge once the port is idle. A primary request wins over a secondary one. A static mode input selects one of two layouts. In word mode the 16 bits form one burst. In split mode they form two 8-bit bursts with one idle bit clock between them. A done output marks the end of the incoming word: in word mode it is a one-cycle low pulse, and in split mode it stays low between the two halves. Each completed incoming word is presented in parallel with a one-cycle valid strobe.

A word received in a secondary frame writes the configuration registers: a control byte and two 6-bit rate-adjust values. During a secondary frame the outgoing sync stays high. Reset loads defined register values and requests a primary frame straight away.

Top module: `codec_sp_ctrl`

## Requirements
- R1: `bit_clk_o` is the master clock divided by four, with a 50% duty cycle (2 cycles high, 2 cycles low). It is high right after reset. Every frame edge follows a rising edge of `bit_clk_o`.
- R2: `in_sync_n_o` is low for exactly 16 bit clocks (64 master clocks) in each frame, whether the frame is primary or secondary. In word mode it forms a single low segment.
- R3: In a primary frame, `out_sync_n_o` is low for 16 bit clocks and `sdo_o` carries `sdo_word_i` MSB first, one bit per bit clock, stable across each falling edge. The MSB is already on `sdo_o` one bit clock before `out_sync_n_o` falls.
- R4: In word mode (`byte_mode_i`=0), `in_done_n_o` drops for exactly one master clock per frame, after the 16th incoming bit has been sampled.
- R5: In split mode (`byte_mode_i`=1), each sync forms two 8-bit low segments separated by one high bit clock. `in_done_n_o` goes low after the 8th incoming bit is sampled and stays low for 36 master clocks, until the 16th bit is sampled. The word contents are the same as in word mode.
- R6: A secondary frame never drives `out_sync_n_o` low.
- R7: While reset is held, both syncs and `in_done_n_o` are high, `rx_valid_o` is 0, `ctrl_o` is 8'hB9 (bits 7..0 = 1,0,1,1,1,0,0,1), and both adjust outputs are 1.
- R8: After reset is released, a primary frame starts without any frame tick.
- R9: `sdi_i` is sampled on falling edges of `bit_clk_o`, MSB first. `rx_valid_o` is a single-cycle pulse carrying the full word on `rx_word_o`, in the same cycle as the word-mode done pulse or the split-mode done release.
- R10: A word received in a secondary frame updates the registers as selected by its bits [1:0]. With 2'b11, `ctrl_o` takes bits [9:2]. With 2'b01, `tx_adj_o` takes bits [14:9] and `rx_adj_o` takes bits [7:2]. Any other selector, and any word received in a primary frame, leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode_i | input | 1 | 1 = two 8-bit bursts, 0 = one 16-bit burst |
| frame_tick_i | input | 1 | Pulse requesting a primary frame |
| sec_req_i | input | 1 | Pulse requesting a secondary frame |
| sdo_word_i | input | 16 | Word sent to the DSP, captured at frame start |
| sdi_i | input | 1 | Serial data from the DSP |
| bit_clk_o | output | 1 | Bit clock, master clock / 4 |
| in_sync_n_o | output | 1 | Active-low sync for bits arriving from the DSP |
| out_sync_n_o | output | 1 | Active-low sync for bits sent to the DSP |
| sdo_o | output | 1 | Serial data to the DSP |
| in_done_n_o | output | 1 | Active-low end-of-incoming-word marker |
| rx_word_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_word_o` |
| ctrl_o | output | 8 | Control register |
| tx_adj_o | output | 6 | Outgoing-direction rate adjust value |
| rx_adj_o | output | 6 | Incoming-direction rate adjust value |

## Verification
The assertions run on every cycle and cover the local timing relations:
- the bit clock's two-cycle phases, and sync edges falling only on bit-clock rises;
- the outgoing sync being low only inside the incoming one, and output data holding across each falling edge;
- the lengths of the valid and done pulses, how the valid strobe lines up with the done marker in each mode, and the register values right after reset.

Some outcomes can only be shown by the bench's scenarios, because they depend on a whole frame:
- the word recovered serially at each end;
- the segment counts and low-time totals in both layouts;
- the outgoing sync staying silent in secondary frames;
- which selector codes write which registers;
- the frame that starts on its own after reset.

// File: rtl/codec_sp_pkg.sv
package codec_sp_pkg;

    localparam int WORD_W = 16;
    localparam int CTRL_W = 8;
    localparam int ADJ_W  = 6;

    localparam logic [CTRL_W-1:0] CTRL_RST = 8'hB9;
    localparam logic [ADJ_W-1:0]  ADJ_RST  = 6'd1;

    localparam logic [1:0] SEL_CTRL = 2'b11;
    localparam logic [1:0] SEL_ADJ  = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BITS,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [ADJ_W-1:0]  tx_adj;
        logic [ADJ_W-1:0]  rx_adj;
    } cfg_t;

    function automatic cfg_t cfg_apply(input cfg_t cur, input logic [WORD_W-1:0] w);
        cfg_t nxt;
        nxt = cur;
        case (w[1:0])
            SEL_CTRL: nxt.ctrl = w[9:2];
            SEL_ADJ: begin
                nxt.tx_adj = w[14:9];
                nxt.rx_adj = w[7:2];
            end
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/csp_bit_clk.sv
module csp_bit_clk (
    input  logic clk,
    input  logic rst,
    output logic bit_clk_o,
    output logic rise_ev_o,
    output logic fall_ev_o
);
    logic [1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= 2'd0;
        else     ph_q <= ph_q + 2'd1;
    end

    assign bit_clk_o = ~ph_q[1];
    assign rise_ev_o = (ph_q == 2'd3);
    assign fall_ev_o = (ph_q == 2'd1);
endmodule

// File: rtl/csp_frame_seq.sv
module csp_frame_seq
    import codec_sp_pkg::*;
#(
    parameter int W     = WORD_W,
    localparam int HALF  = W / 2,
    localparam int CNT_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_ev,
    input  logic             byte_mode,
    input  logic             tick,
    input  logic             sec_req,
    input  logic [W-1:0]     out_word,
    output logic             in_sync_n,
    output logic             out_sync_n,
    output logic             sdo,
    output logic             in_bits,
    output logic [CNT_W-1:0] bit_idx,
    output logic             is_sec
);
    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     sh_q;
    logic             pend_pri_q, pend_sec_q, sec_q;
    logic             take;

    assign take = rise_ev && (state_q == ST_IDLE) && (pend_pri_q || pend_sec_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_pri_q <= 1'b1;
            pend_sec_q <= 1'b0;
        end else begin
            pend_pri_q <= (pend_pri_q && !take) || tick;
            pend_sec_q <= (pend_sec_q && !(take && !pend_pri_q)) || sec_req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            sec_q   <= 1'b0;
        end else if (rise_ev) begin
            case (state_q)
                ST_IDLE: if (take) begin
                    state_q <= ST_LEAD;
                    sh_q    <= out_word;
                    sec_q   <= !pend_pri_q;
                    cnt_q   <= '0;
                end
                ST_LEAD: state_q <= ST_BITS;
                ST_BITS: begin
                    sh_q <= {sh_q[W-2:0], 1'b0};
                    if (cnt_q == CNT_W'(W - 1)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        if (byte_mode && cnt_q == CNT_W'(HALF - 1)) state_q <= ST_GAP;
                    end
                end
                ST_GAP:  state_q <= ST_BITS;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_bits    = (state_q == ST_BITS);
    assign in_sync_n  = !in_bits;
    assign out_sync_n = !(in_bits && !sec_q);
    assign sdo        = sh_q[W-1];
    assign bit_idx    = cnt_q;
    assign is_sec     = sec_q;
endmodule

// File: rtl/csp_rx_capture.sv
module csp_rx_capture #(
    parameter int W     = 16,
    localparam int HALF  = W / 2,
    localparam int CNT_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_ev,
    input  logic             in_bits,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic             byte_mode,
    input  logic             sdi,
    output logic             done_n,
    output logic             valid,
    output logic [W-1:0]     word
);
    logic [W-1:0] sh_q;
    logic         smp, last, mid;

    assign smp  = fall_ev && in_bits;
    assign last = smp && (bit_idx == CNT_W'(W - 1));
    assign mid  = smp && byte_mode && (bit_idx == CNT_W'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            done_n <= 1'b1;
            valid  <= 1'b0;
            word   <= '0;
        end else begin
            valid <= last;
            if (smp) sh_q <= {sh_q[W-2:0], sdi};
            if (last) word <= {sh_q[W-2:0], sdi};
            if (last)            done_n <= byte_mode;
            else if (mid)        done_n <= 1'b0;
            else if (!byte_mode) done_n <= 1'b1;
        end
    end
endmodule

// File: rtl/csp_cfg_regs.sv
module csp_cfg_regs
    import codec_sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.ctrl   <= CTRL_RST;
            cfg.tx_adj <= ADJ_RST;
            cfg.rx_adj <= ADJ_RST;
        end else if (wr_en) begin
            cfg <= cfg_apply(cfg, wr_word);
        end
    end
endmodule

// File: rtl/codec_sp_ctrl.sv
module codec_sp_ctrl
    import codec_sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_mode_i,
    input  logic              frame_tick_i,
    input  logic              sec_req_i,
    input  logic [WORD_W-1:0] sdo_word_i,
    input  logic              sdi_i,
    output logic              bit_clk_o,
    output logic              in_sync_n_o,
    output logic              out_sync_n_o,
    output logic              sdo_o,
    output logic              in_done_n_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [ADJ_W-1:0]  tx_adj_o,
    output logic [ADJ_W-1:0]  rx_adj_o
);
    localparam int CNT_W = $clog2(WORD_W);

    logic             rise_ev, fall_ev, in_bits, is_sec;
    logic [CNT_W-1:0] bit_idx;
    cfg_t             cfg;

    csp_bit_clk clk_i (
        .clk(clk), .rst(rst), .bit_clk_o(bit_clk_o),
        .rise_ev_o(rise_ev), .fall_ev_o(fall_ev)
    );

    csp_frame_seq #(.W(WORD_W)) seq_i (
        .clk(clk), .rst(rst), .rise_ev(rise_ev), .byte_mode(byte_mode_i),
        .tick(frame_tick_i), .sec_req(sec_req_i), .out_word(sdo_word_i),
        .in_sync_n(in_sync_n_o), .out_sync_n(out_sync_n_o), .sdo(sdo_o),
        .in_bits(in_bits), .bit_idx(bit_idx), .is_sec(is_sec)
    );

    csp_rx_capture #(.W(WORD_W)) rx_i (
        .clk(clk), .rst(rst), .fall_ev(fall_ev), .in_bits(in_bits),
        .bit_idx(bit_idx), .byte_mode(byte_mode_i), .sdi(sdi_i),
        .done_n(in_done_n_o), .valid(rx_valid_o), .word(rx_word_o)
    );

    csp_cfg_regs regs_i (
        .clk(clk), .rst(rst), .wr_en(rx_valid_o && is_sec),
        .wr_word(rx_word_o), .cfg(cfg)
    );

    assign ctrl_o   = cfg.ctrl;
    assign tx_adj_o = cfg.tx_adj;
    assign rx_adj_o = cfg.rx_adj;
endmodule

// File: rtl/codec_sp_ctrl_chk.sv
module codec_sp_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       byte_mode_i,
    input logic       bit_clk_o,
    input logic       in_sync_n_o,
    input logic       out_sync_n_o,
    input logic       sdo_o,
    input logic       in_done_n_o,
    input logic       rx_valid_o,
    input logic [7:0] ctrl_o,
    input logic [5:0] tx_adj_o,
    input logic [5:0] rx_adj_o
);
    a_r1_half_period: assert property (@(posedge clk) disable iff (rst)
        !$stable(bit_clk_o) |=> $stable(bit_clk_o));

    a_r1_sync_on_rise: assert property (@(posedge clk) disable iff (rst)
        $fell(in_sync_n_o) |-> $rose(bit_clk_o));

    a_r3_sdo_stable_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!out_sync_n_o && $fell(bit_clk_o)) |-> $stable(sdo_o));

    a_r6_out_inside_in: assert property (@(posedge clk) disable iff (rst)
        !out_sync_n_o |-> !in_sync_n_o);

    a_r4_done_pulse_short: assert property (@(posedge clk) disable iff (rst)
        (!byte_mode_i && !in_done_n_o) |=> in_done_n_o);

    a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    a_r9_valid_word_mode: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && !byte_mode_i) |-> !in_done_n_o);

    a_r9_valid_split_mode: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && byte_mode_i) |-> $rose(in_done_n_o));

    a_r7_reset_values: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_o == 8'hB9 && tx_adj_o == 6'd1 && rx_adj_o == 6'd1));
endmodule

bind codec_sp_ctrl codec_sp_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .byte_mode_i(byte_mode_i), .bit_clk_o(bit_clk_o),
    .in_sync_n_o(in_sync_n_o), .out_sync_n_o(out_sync_n_o), .sdo_o(sdo_o),
    .in_done_n_o(in_done_n_o), .rx_valid_o(rx_valid_o), .ctrl_o(ctrl_o),
    .tx_adj_o(tx_adj_o), .rx_adj_o(rx_adj_o)
);

// File: tb/codec_sp_ctrl_tb_top.sv
`timescale 1ns/1ps
module codec_sp_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_mode_i = 1'b0;
    logic        frame_tick_i = 1'b0;
    logic        sec_req_i = 1'b0;
    logic [15:0] sdo_word_i = 16'h0;
    logic        sdi_i = 1'b0;
    logic        bit_clk_o, in_sync_n_o, out_sync_n_o, sdo_o, in_done_n_o, rx_valid_o;
    logic [15:0] rx_word_o;
    logic [7:0]  ctrl_o;
    logic [5:0]  tx_adj_o, rx_adj_o;

    always #2 clk = ~clk;

    codec_sp_ctrl dut_i (
        .clk(clk), .rst(rst), .byte_mode_i(byte_mode_i), .frame_tick_i(frame_tick_i),
        .sec_req_i(sec_req_i), .sdo_word_i(sdo_word_i), .sdi_i(sdi_i),
        .bit_clk_o(bit_clk_o), .in_sync_n_o(in_sync_n_o), .out_sync_n_o(out_sync_n_o),
        .sdo_o(sdo_o), .in_done_n_o(in_done_n_o), .rx_word_o(rx_word_o),
        .rx_valid_o(rx_valid_o), .ctrl_o(ctrl_o), .tx_adj_o(tx_adj_o), .rx_adj_o(rx_adj_o)
    );

    int checks = 0;
    int errors = 0;

    logic [15:0] dsp_word = 16'h0;
    logic [15:0] got = 16'h0;
    logic [15:0] valid_word = 16'h0;
    int k = 0;
    int in_low = 0, out_low = 0, done_low = 0;
    int in_seg = 0, out_seg = 0, done_seg = 0, valid_cnt = 0;
    logic done_at_valid = 1'b1;
    logic msb_seen = 1'b0;
    logic p_bclk = 1'b1, p_in = 1'b1, p_out = 1'b1, p_done = 1'b1, p_sdo = 1'b0;

    // DSP model and monitor, all sampled at the falling master clock edge
    always @(negedge clk) begin
        if (bit_clk_o && !p_bclk && !in_sync_n_o && k < 16) begin
            sdi_i <= dsp_word[15 - k];
            k = k + 1;
        end
        if (!bit_clk_o && p_bclk && !out_sync_n_o) got = {got[14:0], sdo_o};
        if (!out_sync_n_o && p_out) msb_seen = p_sdo;
        if (!in_sync_n_o) in_low++;
        if (!out_sync_n_o) out_low++;
        if (!in_done_n_o) done_low++;
        if (!in_sync_n_o && p_in) in_seg++;
        if (!out_sync_n_o && p_out) out_seg++;
        if (!in_done_n_o && p_done) done_seg++;
        if (rx_valid_o) begin
            valid_cnt++;
            valid_word = rx_word_o;
            done_at_valid = in_done_n_o;
        end
        p_bclk = bit_clk_o; p_in = in_sync_n_o; p_out = out_sync_n_o;
        p_done = in_done_n_o; p_sdo = sdo_o;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon(input logic [15:0] dw);
        dsp_word = dw; k = 0; got = 16'h0;
        in_low = 0; out_low = 0; done_low = 0;
        in_seg = 0; out_seg = 0; done_seg = 0; valid_cnt = 0;
        done_at_valid = 1'b1; msb_seen = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 600 && valid_cnt == 0; i++) @(negedge clk);
        repeat (16) @(negedge clk);
    endtask

    task automatic run_frame(input bit sec, input bit bmode, input logic [15:0] dw, input logic [15:0] ow);
        @(negedge clk);
        byte_mode_i = bmode;
        sdo_word_i = ow;
        clear_mon(dw);
        if (sec) sec_req_i = 1'b1; else frame_tick_i = 1'b1;
        @(negedge clk);
        sec_req_i = 1'b0; frame_tick_i = 1'b0;
        wait_done();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        sdo_word_i = 16'hC3A5;
        repeat (6) @(negedge clk);
        chk("R7", "in sync idle", in_sync_n_o, 1);
        chk("R7", "out sync idle", out_sync_n_o, 1);
        chk("R7", "done idle", in_done_n_o, 1);
        chk("R7", "valid idle", rx_valid_o, 0);
        chk("R7", "ctrl", ctrl_o, 8'hB9);
        chk("R7", "tx adj", tx_adj_o, 6'd1);
        chk("R7", "rx adj", rx_adj_o, 6'd1);
        clear_mon(16'h1E2D);
        rst = 1'b0;
        wait_done();
        chk("R8", "auto frame valid", valid_cnt, 1);
        chk("R8", "auto frame word", valid_word, 16'h1E2D);
        chk("R8", "auto frame sdo", got, 16'hC3A5);
    endtask

    task automatic t_bit_clk();
        int highs = 0, changes = 0;
        logic prev;
        @(negedge clk);
        prev = bit_clk_o;
        highs = bit_clk_o ? 1 : 0;
        for (int i = 1; i < 8; i++) begin
            @(negedge clk);
            if (bit_clk_o) highs++;
            if (bit_clk_o != prev) changes++;
            prev = bit_clk_o;
        end
        chk("R1", "bit clock high count in 8", highs, 4);
        chk("R1", "bit clock edges in 8", changes, 3);
    endtask

    task automatic t_word(input logic [15:0] dw, input logic [15:0] ow);
        run_frame(1'b0, 1'b0, dw, ow);
        chk("R2", "in sync low clocks", in_low, 64);
        chk("R2", "in sync segments", in_seg, 1);
        chk("R3", "out sync low clocks", out_low, 64);
        chk("R3", "sdo word", got, ow);
        chk("R3", "msb ahead of sync", msb_seen, ow[15]);
        chk("R4", "done low clocks", done_low, 1);
        chk("R9", "valid pulses", valid_cnt, 1);
        chk("R9", "rx word", valid_word, dw);
        chk("R9", "done low with valid", done_at_valid, 0);
        chk("R10", "primary frame leaves ctrl", ctrl_o, 8'hB9);
    endtask

    task automatic t_split(input logic [15:0] dw, input logic [15:0] ow);
        run_frame(1'b0, 1'b1, dw, ow);
        chk("R5", "in sync low clocks", in_low, 64);
        chk("R5", "in sync segments", in_seg, 2);
        chk("R5", "out sync segments", out_seg, 2);
        chk("R5", "done low clocks", done_low, 36);
        chk("R5", "done segments", done_seg, 1);
        chk("R5", "sdo word", got, ow);
        chk("R9", "rx word split", valid_word, dw);
        chk("R9", "done released with valid", done_at_valid, 1);
    endtask

    task automatic t_secondary();
        run_frame(1'b1, 1'b0, 16'h0000 | (16'h5A << 2) | 16'h3, 16'hFFFF);
        chk("R6", "out sync silent", out_low, 0);
        chk("R2", "in sync low secondary", in_low, 64);
        chk("R10", "ctrl written", ctrl_o, 8'h5A);
        run_frame(1'b1, 1'b0, 16'h4A31, 16'h0);
        chk("R10", "tx adj written", tx_adj_o, 6'd37);
        chk("R10", "rx adj written", rx_adj_o, 6'd12);
        chk("R10", "ctrl kept on adj write", ctrl_o, 8'h5A);
        run_frame(1'b1, 1'b1, 16'hFFFE, 16'h0);
        chk("R10", "ignored selector ctrl", ctrl_o, 8'h5A);
        chk("R10", "ignored selector tx adj", tx_adj_o, 6'd37);
        chk("R6", "out sync silent split", out_low, 0);
        run_frame(1'b0, 1'b0, 16'hFFFF, 16'h0);
        chk("R10", "primary word ignored", ctrl_o, 8'h5A);
        chk("R10", "primary adj ignored", rx_adj_o, 6'd12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual run still going, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_bit_clk();
        t_word(16'hA55A, 16'h3C96);
        t_word(16'h8001, 16'h7FFE);
        t_split(16'h96C3, 16'h0F1E);
        t_split(16'h00FF, 16'hFF00);
        t_secondary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule